// File: doc/BRIEF.md
# I2C Master SCL Clock Generator with Stretch Following

This block produces the serial clock of an I2C master. A down-counter sets the length of each half period. It is reloaded from an 8-bit value and decrements only on a count-enable tick. The tick stands for the two counting phases of an instruction cycle, so in practice it is asserted on two evenly spaced clocks out of every four. The block pulls SCL low through an open-drain style output, or releases it. It samples the wire through a two-flop synchronizer.

During the low half the counter runs freely from its reload value down to zero, then the block releases SCL. The counter is then suspended. It does not start the high half until the synchronized line actually reads high. This is how the block follows a slave that stretches the clock by holding SCL low. Because the reload happens only once the line is seen high, the high half always lasts a full count after any stretch.

A one-cycle pulse marks the end of each low half and each high half. A sequencer uses these pulses to place SDA changes while SCL is low. The block runs only while its enable is high. When disabled it releases SCL and clears its counter.

Top module: `i2c_scl_gen`

## Requirements
- R1: While reset is asserted and after it is released with enable low, scl_drive_low, low_end and high_end are all 0.
- R2: A low half begins when the block enters it (on enable, or in the cycle after a high_end pulse). During the low half scl_drive_low is 1. The counter is loaded with the reload value and decremented on each tick. Exactly N tick cycles pass before the low_end cycle, where N is the reload value. In the cycle after low_end, scl_drive_low is 0.
- R3: While SCL is released but the line is still read low (stretching), the counter is suspended. No pulse is produced and scl_drive_low stays 0, for as long as the stretch lasts.
- R4: The high half starts only when the synchronized line reads high. With the default two-stage synchronizer, the counter is reloaded three clocks after the line rises. It then counts N ticks before high_end. Seen from the line, the number of tick cycles with the line high before the high_end cycle is therefore between N+1 and N+2 when ticks alternate every clock. The cycle after high_end starts a new low half.
- R5: low_end and high_end are single-cycle pulses. low_end occurs only while scl_drive_low is 1, and high_end only while it is 0.
- R6: A reload value of 0 behaves exactly like a reload value of 1.
- R7: When enable is low, scl_drive_low is 0 and no pulse appears, from the next cycle onward. This holds in any phase, including during a stretch. A new enable starts with a complete low half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enable | input | 1 | Run request from the sequencer; low stops and releases the clock |
| tick | input | 1 | Count enable for the half-period counter |
| reload_val | input | CNT_W | Half-period length in ticks (0 treated as 1) |
| scl_in | input | 1 | Sampled level of the SCL wire |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| low_end | output | 1 | One-cycle pulse at the end of a low half |
| high_end | output | 1 | One-cycle pulse at the end of a high half |

## Verification
The bench sweeps reload values 0 to 20 and 255 against stretch lengths of zero, one, a few and many clocks. For every half period it counts the tick cycles from the outputs and the modelled wire. Suppose a design counted during the stretch, or reloaded on release instead of on the synchronized high. Its high half would come out short by the stretch length and miss the N+1 to N+2 window. A zero reload mishandled as 256 or as a stall shows up in the low tick count. Pulses wider than one cycle, or pulses while disabled mid-stretch, are caught at the ports directly.

// File: rtl/i2c_scl_pkg.sv
package i2c_scl_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } scl_phase_e;

endpackage

// File: rtl/scl_bit_sync.sv
module scl_bit_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_d;
  logic [STAGES-1:0] chain_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      assign chain_d[i] = d;
    end else begin : g_next
      assign chain_d[i] = chain_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/scl_half_counter.sv
module scl_half_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic             dec,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             zero
);

  localparam logic [CNT_W-1:0] MIN_LOAD = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (load) begin
      cnt_d = (load_val == '0) ? MIN_LOAD : load_val;
    end else if (dec && (cnt_q != '0)) begin
      cnt_d = cnt_q - MIN_LOAD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt  = cnt_q;
  assign zero = (cnt_q == '0);

  // R2: at zero the count holds, it never wraps to the top
  p_hold_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !load && cnt_q == '0) |=> (cnt_q == '0));

  // R6: a load never leaves the counter at zero
  p_reload_min_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clr) |=> (cnt_q != '0));

  // R3: without a count enable or load the value is frozen
  p_suspend_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec && !load && !clr) |=> $stable(cnt_q));

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import i2c_scl_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             scl_sync,
  input  logic             zero,
  input  logic [CNT_W-1:0] cnt,
  output logic             load,
  output logic             clr,
  output logic             dec,
  output logic             drive_low,
  output logic             low_end,
  output logic             high_end
);

  scl_phase_e state_d;
  scl_phase_e state_q;

  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    low_end  = 1'b0;
    high_end = 1'b0;
    clr      = !en;
    dec      = (state_q == PH_LOW) || (state_q == PH_HIGH);
    unique case (state_q)
      PH_IDLE: begin
        if (en) begin
          state_d = PH_LOW;
          load    = 1'b1;
        end
      end
      PH_LOW: begin
        if (!en) begin
          state_d = PH_IDLE;
        end else if (zero) begin
          state_d = PH_WAIT;
          low_end = 1'b1;
        end
      end
      PH_WAIT: begin
        if (!en) begin
          state_d = PH_IDLE;
        end else if (scl_sync) begin
          state_d = PH_HIGH;
          load    = 1'b1;
        end
      end
      PH_HIGH: begin
        if (!en) begin
          state_d = PH_IDLE;
        end else if (zero) begin
          state_d  = PH_LOW;
          load     = 1'b1;
          high_end = 1'b1;
        end
      end
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PH_IDLE;
    else        state_q <= state_d;
  end

  assign drive_low = (state_q == PH_LOW);

  // R2: the end of a low half releases the line next cycle
  p_low_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    low_end |=> !drive_low);

  // R4: the end of a high half pulls the line low with a fresh count
  p_high_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    high_end |=> (drive_low && cnt != '0));

  // R4: a synchronized high while waiting starts a full count
  p_wait_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_WAIT && scl_sync && en) |=> (cnt != '0 && !drive_low));

  // R3: while the line is still low after release, nothing advances
  p_stretch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_WAIT && !scl_sync && en) |=> ($stable(cnt) && !low_end && !high_end));

  // R5: both boundary marks last a single cycle
  p_single_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    low_end |=> !low_end);
  p_single_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    high_end |=> !high_end);

  // R7: disabling releases the line and silences the marks
  p_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!drive_low && !low_end && !high_end && cnt == '0));

endmodule

// File: rtl/i2c_scl_gen.sv
module i2c_scl_gen #(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             tick,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             scl_in,
  output logic             scl_drive_low,
  output logic             low_end,
  output logic             high_end
);

  localparam int RST_STAGES = 2;

  logic             rst_n_int;
  logic             scl_sync;
  logic             zero;
  logic             load;
  logic             clr;
  logic             dec_req;
  logic [CNT_W-1:0] cnt;

  scl_bit_sync #(.STAGES(RST_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_n_int)
  );

  scl_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
    .clk   (clk),
    .rst_n (rst_n_int),
    .d     (scl_in),
    .q     (scl_sync)
  );

  scl_half_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .clr      (clr),
    .load     (load),
    .dec      (dec_req && tick),
    .load_val (reload_val),
    .cnt      (cnt),
    .zero     (zero)
  );

  scl_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .en        (enable),
    .scl_sync  (scl_sync),
    .zero      (zero),
    .cnt       (cnt),
    .load      (load),
    .clr       (clr),
    .dec       (dec_req),
    .drive_low (scl_drive_low),
    .low_end   (low_end),
    .high_end  (high_end)
  );

  // R1: held quiet throughout reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n_int |-> (!scl_drive_low && !low_end && !high_end));

  // R5: the marks line up with the line level
  p_low_mark_r5: assert property (@(posedge clk) disable iff (!rst_n_int)
    $fell(scl_drive_low) |-> $past(low_end) || !$past(enable));

endmodule

// File: tb/i2c_scl_gen_tb_top.sv
`timescale 1ns/1ps
module i2c_scl_gen_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       tick = 1'b0;
  logic [7:0] reload_val = 8'd0;
  logic       hold_low = 1'b0;
  logic       scl_line;
  logic       scl_drive_low;
  logic       low_end;
  logic       high_end;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) tick <= ~tick;

  assign scl_line = !(scl_drive_low || hold_low);

  i2c_scl_gen dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (enable),
    .tick          (tick),
    .reload_val    (reload_val),
    .scl_in        (scl_line),
    .scl_drive_low (scl_drive_low),
    .low_end       (low_end),
    .high_end      (high_end)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_case(input int n, input int s);
    int eff;
    int cnt;
    eff = (n == 0) ? 1 : n;
    reload_val = n[7:0];
    enable = 1'b1;
    @(negedge clk);
    while (!scl_drive_low) @(negedge clk);
    for (int p = 0; p < 2; p++) begin
      cnt = 0;
      while (!low_end) begin
        if (high_end) chk(1'b0, "R5 high_end in low half", 1, 0);
        if (tick) cnt++;
        @(negedge clk);
      end
      chk(cnt == eff, (n == 0) ? "R6 low ticks" : "R2 low ticks", cnt, eff);
      chk(scl_drive_low, "R5 low_end while driven", scl_drive_low, 1);
      hold_low = (s > 0);
      @(negedge clk);
      chk(!low_end, "R5 low_end width", low_end, 0);
      chk(!scl_drive_low, "R2 release after low_end", scl_drive_low, 0);
      for (int i = 0; i < s; i++) begin
        chk(!low_end && !high_end && !scl_drive_low, "R3 quiet during stretch",
            {low_end, high_end, scl_drive_low}, 0);
        if (i == s - 1) hold_low = 1'b0;
        @(negedge clk);
      end
      cnt = 0;
      while (!high_end) begin
        if (low_end) chk(1'b0, "R5 low_end in high half", 1, 0);
        if (scl_line && tick) cnt++;
        @(negedge clk);
      end
      chk(cnt >= eff + 1 && cnt <= eff + 2, "R4 high ticks after line high", cnt, eff + 1);
      chk(!scl_drive_low, "R5 high_end while released", scl_drive_low, 0);
      @(negedge clk);
      chk(!high_end, "R5 high_end width", high_end, 0);
      chk(scl_drive_low, "R4 drive low after high_end", scl_drive_low, 1);
    end
    enable = 1'b0;
    @(negedge clk);
    chk(!scl_drive_low, "R7 release on disable", scl_drive_low, 1'b0);
    cnt = 0;
    for (int i = 0; i < 8; i++) begin
      if (low_end || high_end || scl_drive_low) cnt++;
      @(negedge clk);
    end
    chk(cnt == 0, "R7 quiet while disabled", cnt, 0);
  endtask

  initial begin
    int act;
    #1;
    chk(!scl_drive_low && !low_end && !high_end, "R1 in reset",
        {scl_drive_low, low_end, high_end}, 0);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    act = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (scl_drive_low || low_end || high_end) act++;
    end
    chk(act == 0, "R1 idle after reset", act, 0);

    for (int n = 0; n <= 21; n++) begin
      int rv;
      rv = (n == 21) ? 255 : n;
      run_case(rv, 0);
      run_case(rv, 1);
      run_case(rv, 4);
      run_case(rv, 13);
    end

    // disable while a slave is stretching the clock
    reload_val = 8'd3;
    enable = 1'b1;
    @(negedge clk);
    while (!low_end) @(negedge clk);
    hold_low = 1'b1;
    repeat (3) @(negedge clk);
    enable = 1'b0;
    act = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (i == 2) hold_low = 1'b0;
      if (scl_drive_low || low_end || high_end) act++;
    end
    chk(act == 0, "R7 disable during stretch", act, 0);
    run_case(6, 2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1500000;
    errors++;
    checks++;
    $display("FAIL watchdog R2 actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule